// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point numbers. A number has a sign bit, an 8-bit exponent field with bias 127 and a 23-bit fraction. A normal number has an implied leading one. An exponent field of zero holds zero or a denormal value, which has no implied one. A field of all ones holds infinity when the fraction is zero, and NaN otherwise. An operation select flips the sign of the second operand, so the same hardware does both addition and subtraction. A 2-bit input picks one of four rounding modes for each operation.

The work is split across three register stages:
- **Alignment.** Special operands are classified, the operands are ordered by magnitude, and the smaller significand is shifted right. Three extra low bits are kept below it: guard, round and sticky. The sticky bit collects every bit shifted out past the round position.
- **Add and normalize.** The significands are added or subtracted. The result is normalized by a one-place right shift, or by a left shift that stops at the denormal boundary.
- **Round and pack.** The result is rounded, renormalized if rounding carries out, checked for overflow, and packed.

A new operation can enter on every clock. Each result is registered together with its overflow, underflow and invalid flags.

Top module: `fpadd32_pipe`

## Requirements
- R1: An operation presented with `in_valid` high produces `out_valid` high exactly three clock edges later. `out_valid` is low in every other cycle, and back-to-back operations are accepted one per clock.
- R2: For finite operands, in round-to-nearest-even mode (`rnd_mode` = 00), the result equals the exact sum rounded to nearest-even. Ties go to the candidate with an even last fraction bit.
- R3: With `op_sub` high, the result is `op_a` minus `op_b`. This holds for every operand class.
- R4: Alignment keeps guard, round and sticky information. A dropped part exactly half an ulp is a tie. Any nonzero bits shifted far below the significand still count as above zero when rounding.
- R5: `rnd_mode` 01 truncates toward zero. 10 rounds toward +infinity. 11 rounds toward -infinity.
- R6: After cancellation the result is renormalized by a left shift, with the exponent reduced by the shift distance.
- R7: Denormal operands are added exactly. A carry out of a denormal sum gives the smallest normal number (exponent field 1).
- R8: A NaN on either input, or infinities of opposite effective sign, give the quiet NaN 0x7FC00000 with `flag_inv` high.
- R9: An infinite operand combined with a finite one, or with an infinity of the same effective sign, gives that infinity with all flags low.
- R10: An exact zero from operands of opposite effective sign is +0, except in mode 11, where it is -0. Two zeros of the same sign keep that sign.
- R11: If the rounded exponent exceeds 254, `flag_ovf` is raised. The result is then infinity in mode 00, in mode 10 for positive results and in mode 11 for negative results. Otherwise it is the largest finite magnitude (exponent 254, fraction all ones) with the result's sign.
- R12: `flag_unf` is raised exactly when the result is finite, has a zero exponent field and a nonzero fraction.
- R13: While `rst` is high at a clock edge, `out_valid`, `sum_out` and all flags are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1: subtract `op_b` from `op_a` |
| rnd_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result valid |
| sum_out | output | 32 | Rounded result |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Result is denormal |
| flag_inv | output | 1 | Invalid operation, NaN returned |

## Verification
The rounding increment and the overflow test can act in the same cycle. This happens when a value just under the largest finite magnitude gains half an ulp and the increment carries into an exponent of 255. The same kind of carry can turn a denormal sum into the smallest normal number.

Directed operands provoke both cases under all four modes: the largest finite value plus exactly half an ulp, and denormals whose sum reaches the implied-one position. The outputs are judged against a behavioural model that computes the exact sum on wide integers and rounds it independently. Random operands with nearby exponents add heavy cancellation and tie cases, and run through the pipeline with no gaps.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_t;
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int EXT_W  = SIG_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic              sub,
  input  logic [1:0]        rm,
  output logic              s1_valid,
  output logic              s1_sign,
  output logic              s1_opsub,
  output logic [EXP_W-1:0]  s1_exp,
  output logic [EXT_W-1:0]  s1_big,
  output logic [EXT_W-1:0]  s1_small,
  output logic [1:0]        s1_rm,
  output logic              s1_spec,
  output logic              s1_inv,
  output logic [W-1:0]      s1_specval
);
  localparam logic [EXP_W-1:0] EMAX = {EXP_W{1'b1}};
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic              a_nan, b_nan, a_inf, b_inf;
  logic              a_big;
  logic [EXP_W-1:0]  e_big, e_small, diff;
  logic [SIG_W-1:0]  g_big, g_small;
  logic [EXT_W-1:0]  ext_small, shifted;
  logic              spec, inv;
  logic [W-1:0]      specval;

  always_comb begin
    sa = a[W-1];
    sb = b[W-1] ^ sub;
    ea = a[W-2:FRAC_W];
    eb = b[W-2:FRAC_W];
    fa = a[FRAC_W-1:0];
    fb = b[FRAC_W-1:0];
    a_nan = (ea == EMAX) && (fa != '0);
    b_nan = (eb == EMAX) && (fb != '0);
    a_inf = (ea == EMAX) && (fa == '0);
    b_inf = (eb == EMAX) && (fb == '0);
    // order by magnitude: exponent field then fraction
    a_big = a[W-2:0] >= b[W-2:0];
    if (a_big) begin
      e_big   = (ea == '0) ? EXP_W'(1) : ea;
      e_small = (eb == '0) ? EXP_W'(1) : eb;
      g_big   = {ea != '0, fa};
      g_small = {eb != '0, fb};
    end else begin
      e_big   = (eb == '0) ? EXP_W'(1) : eb;
      e_small = (ea == '0) ? EXP_W'(1) : ea;
      g_big   = {eb != '0, fb};
      g_small = {ea != '0, fa};
    end
    diff      = e_big - e_small;
    ext_small = {g_small, 3'b000};
    // right shift with guard/round kept and everything below folded into sticky
    if (diff >= EXP_W'(EXT_W)) begin
      shifted    = '0;
      shifted[0] = |ext_small;
    end else begin
      shifted    = ext_small >> diff;
      shifted[0] = shifted[0] | (|(ext_small & ~({EXT_W{1'b1}} << diff)));
    end
    spec    = a_nan | b_nan | a_inf | b_inf;
    inv     = a_nan | b_nan | (a_inf & b_inf & (sa != sb));
    if (inv)        specval = QNAN;
    else if (a_inf) specval = {sa, EMAX, {FRAC_W{1'b0}}};
    else if (b_inf) specval = {sb, EMAX, {FRAC_W{1'b0}}};
    else            specval = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_sign    <= 1'b0;
      s1_opsub   <= 1'b0;
      s1_exp     <= '0;
      s1_big     <= '0;
      s1_small   <= '0;
      s1_rm      <= '0;
      s1_spec    <= 1'b0;
      s1_inv     <= 1'b0;
      s1_specval <= '0;
    end else begin
      s1_valid   <= in_valid;
      s1_sign    <= a_big ? sa : sb;
      s1_opsub   <= sa ^ sb;
      s1_exp     <= e_big;
      s1_big     <= {g_big, 3'b000};
      s1_small   <= shifted;
      s1_rm      <= rm;
      s1_spec    <= spec;
      s1_inv     <= inv;
      s1_specval <= specval;
    end
  end

  // R8: an invalid operation is always carried down the special path
  assert_inv_is_special_R8: assert property (@(posedge clk) disable iff (rst)
    s1_valid && s1_inv |-> s1_spec);
endmodule

// File: rtl/fpadd_sum_norm.sv
module fpadd_sum_norm
  import fpadd_pkg::*;
#(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int EXT_W  = SIG_W + 3,
  localparam int EW     = EXP_W + 1,
  localparam int POS_W  = $clog2(EXT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic              s1_sign,
  input  logic              s1_opsub,
  input  logic [EXP_W-1:0]  s1_exp,
  input  logic [EXT_W-1:0]  s1_big,
  input  logic [EXT_W-1:0]  s1_small,
  input  logic [1:0]        s1_rm,
  input  logic              s1_spec,
  input  logic              s1_inv,
  input  logic [W-1:0]      s1_specval,
  output logic              s2_valid,
  output logic              s2_sign,
  output logic [EW-1:0]     s2_exp,
  output logic [EXT_W-1:0]  s2_sig,
  output logic [1:0]        s2_rm,
  output logic              s2_spec,
  output logic              s2_inv,
  output logic [W-1:0]      s2_specval
);
  logic [EXT_W:0]   sum;
  logic [EW-1:0]    ex, lim, sh, n_exp;
  logic [POS_W-1:0] lz;
  logic             found, n_sign;
  logic [EXT_W-1:0] n_sig;

  always_comb begin
    sum = s1_opsub ? ({1'b0, s1_big} - {1'b0, s1_small})
                   : ({1'b0, s1_big} + {1'b0, s1_small});
    ex    = {1'b0, s1_exp};
    lz    = POS_W'(EXT_W - 1);
    found = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found && sum[i]) begin
        lz    = POS_W'(EXT_W - 1 - i);
        found = 1'b1;
      end
    end
    // left shift may not take the exponent below the denormal floor
    lim    = ex - EW'(1);
    sh     = (EW'(lz) < lim) ? EW'(lz) : lim;
    n_sign = s1_sign;
    if (sum == '0) begin
      n_exp  = EW'(1);
      n_sig  = '0;
      n_sign = s1_opsub ? (s1_rm == RM_DOWN) : s1_sign;
    end else if (sum[EXT_W]) begin
      n_exp = ex + EW'(1);
      n_sig = {sum[EXT_W:2], |sum[1:0]};
    end else begin
      n_exp = ex - sh;
      n_sig = sum[EXT_W-1:0] << sh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid   <= 1'b0;
      s2_sign    <= 1'b0;
      s2_exp     <= '0;
      s2_sig     <= '0;
      s2_rm      <= '0;
      s2_spec    <= 1'b0;
      s2_inv     <= 1'b0;
      s2_specval <= '0;
    end else begin
      s2_valid   <= s1_valid;
      s2_sign    <= n_sign;
      s2_exp     <= n_exp;
      s2_sig     <= n_sig;
      s2_rm      <= s1_rm;
      s2_spec    <= s1_spec;
      s2_inv     <= s1_inv;
      s2_specval <= s1_specval;
    end
  end

  // R6: above the denormal floor the normalized significand has its leading one on top
  assert_norm_lead_R6: assert property (@(posedge clk) disable iff (rst)
    s2_valid && !s2_spec && (s2_exp > EW'(1)) |-> s2_sig[EXT_W-1]);
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
#(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int EXT_W  = SIG_W + 3,
  localparam int EW     = EXP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s2_valid,
  input  logic              s2_sign,
  input  logic [EW-1:0]     s2_exp,
  input  logic [EXT_W-1:0]  s2_sig,
  input  logic [1:0]        s2_rm,
  input  logic              s2_spec,
  input  logic              s2_inv,
  input  logic [W-1:0]      s2_specval,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic              ovf,
  output logic              unf,
  output logic              inv
);
  localparam logic [EW-1:0]    EMAX_X = {1'b0, {EXP_W{1'b1}}};
  localparam logic [EXP_W-1:0] EMAX   = {EXP_W{1'b1}};

  rmode_t           rmode;
  logic [SIG_W-1:0] m, mant;
  logic             g, r, st, any, inc, to_inf;
  logic [SIG_W:0]   m2;
  logic [EW-1:0]    e2, field;
  logic [W-1:0]     n_res;
  logic             n_ovf, n_unf;

  always_comb begin
    rmode = rmode_t'(s2_rm);
    m   = s2_sig[EXT_W-1:3];
    g   = s2_sig[2];
    r   = s2_sig[1];
    st  = s2_sig[0];
    any = g | r | st;
    unique case (rmode)
      RM_NEAR: inc = g & (r | st | m[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~s2_sign & any;
      RM_DOWN: inc = s2_sign & any;
      default: inc = 1'b0;
    endcase
    m2 = {1'b0, m} + {{SIG_W{1'b0}}, inc};
    // carry out of the significand: renormalize by one place
    if (m2[SIG_W]) begin
      mant = m2[SIG_W:1];
      e2   = s2_exp + EW'(1);
    end else begin
      mant = m2[SIG_W-1:0];
      e2   = s2_exp;
    end
    field  = mant[SIG_W-1] ? e2 : '0;
    to_inf = (rmode == RM_NEAR) || (rmode == RM_UP && !s2_sign) ||
             (rmode == RM_DOWN && s2_sign);
    n_ovf  = 1'b0;
    n_unf  = 1'b0;
    if (s2_spec) begin
      n_res = s2_specval;
    end else if (field >= EMAX_X) begin
      n_ovf = 1'b1;
      n_res = to_inf ? {s2_sign, EMAX, {FRAC_W{1'b0}}}
                     : {s2_sign, EMAX - EXP_W'(1), {FRAC_W{1'b1}}};
    end else begin
      n_res = {s2_sign, field[EXP_W-1:0], mant[FRAC_W-1:0]};
      n_unf = (field == '0) && (mant[FRAC_W-1:0] != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
      inv       <= 1'b0;
    end else begin
      out_valid <= s2_valid;
      result    <= n_res;
      ovf       <= n_ovf & s2_valid;
      unf       <= n_unf & s2_valid;
      inv       <= s2_inv & s2_spec & s2_valid;
    end
  end

  assert_inv_qnan_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && inv |-> (result[W-2:FRAC_W] == EMAX) && result[FRAC_W-1]);

  assert_ovf_value_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid && ovf |->
      ((result[W-2:FRAC_W] == EMAX) && (result[FRAC_W-1:0] == '0)) ||
      ((result[W-2:FRAC_W] == EMAX - EXP_W'(1)) && (&result[FRAC_W-1:0])));

  assert_unf_denorm_R12: assert property (@(posedge clk) disable iff (rst)
    out_valid && unf |-> (result[W-2:FRAC_W] == '0) && (result[FRAC_W-1:0] != '0));

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf, unf, inv}));
endmodule

// File: rtl/fpadd32_pipe.sv
module fpadd32_pipe #(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int EXT_W  = FRAC_W + 4,
  localparam int EW     = EXP_W + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         op_sub,
  input  logic [1:0]   rnd_mode,
  output logic         out_valid,
  output logic [W-1:0] sum_out,
  output logic         flag_ovf,
  output logic         flag_unf,
  output logic         flag_inv
);
  logic             s1_valid, s1_sign, s1_opsub, s1_spec, s1_inv;
  logic [EXP_W-1:0] s1_exp;
  logic [EXT_W-1:0] s1_big, s1_small;
  logic [1:0]       s1_rm;
  logic [W-1:0]     s1_specval;

  logic             s2_valid, s2_sign, s2_spec, s2_inv;
  logic [EW-1:0]    s2_exp;
  logic [EXT_W-1:0] s2_sig;
  logic [1:0]       s2_rm;
  logic [W-1:0]     s2_specval;

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(op_a), .b(op_b),
    .sub(op_sub), .rm(rnd_mode),
    .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_opsub(s1_opsub),
    .s1_exp(s1_exp), .s1_big(s1_big), .s1_small(s1_small), .s1_rm(s1_rm),
    .s1_spec(s1_spec), .s1_inv(s1_inv), .s1_specval(s1_specval)
  );

  fpadd_sum_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_opsub(s1_opsub),
    .s1_exp(s1_exp), .s1_big(s1_big), .s1_small(s1_small), .s1_rm(s1_rm),
    .s1_spec(s1_spec), .s1_inv(s1_inv), .s1_specval(s1_specval),
    .s2_valid(s2_valid), .s2_sign(s2_sign), .s2_exp(s2_exp), .s2_sig(s2_sig),
    .s2_rm(s2_rm), .s2_spec(s2_spec), .s2_inv(s2_inv), .s2_specval(s2_specval)
  );

  fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .clk(clk), .rst(rst),
    .s2_valid(s2_valid), .s2_sign(s2_sign), .s2_exp(s2_exp), .s2_sig(s2_sig),
    .s2_rm(s2_rm), .s2_spec(s2_spec), .s2_inv(s2_inv), .s2_specval(s2_specval),
    .out_valid(out_valid), .result(sum_out), .ovf(flag_ovf), .unf(flag_unf),
    .inv(flag_inv)
  );

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid);
endmodule

// File: tb/fpadd32_pipe_tb_top.sv
module fpadd32_pipe_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, in_valid, op_sub, out_valid, flag_ovf, flag_unf, flag_inv;
  logic [31:0] op_a, op_b, sum_out;
  logic [1:0]  rnd_mode;

  fpadd32_pipe dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .rnd_mode(rnd_mode), .out_valid(out_valid),
    .sum_out(sum_out), .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inv(flag_inv)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct packed {
    logic        v;
    logic [31:0] r;
    logic        o, u, i;
  } exp_t;
  exp_t  eq[$];
  string tq[$];

  // exact reference: both operands as integers in units of 2^-149, then rounded
  function automatic logic [34:0] ref_add(input logic [31:0] x, input logic [31:0] y,
                                          input logic s, input logic [1:0] m);
    logic sx, sy, rs, inc;
    logic [7:0] ex, ey;
    logic [22:0] fx, fy;
    logic [299:0] mx, my, mm, q, rem, half, ones;
    int p, sh, fld;
    sx = x[31]; sy = y[31] ^ s;
    ex = x[30:23]; ey = y[30:23];
    fx = x[22:0]; fy = y[22:0];
    if ((ex == 8'hFF && fx != 0) || (ey == 8'hFF && fy != 0) ||
        (ex == 8'hFF && ey == 8'hFF && sx != sy))
      return {32'h7FC00000, 3'b001};
    if (ex == 8'hFF) return {sx, 8'hFF, 23'h0, 3'b000};
    if (ey == 8'hFF) return {sy, 8'hFF, 23'h0, 3'b000};
    mx = 300'({ex != 0, fx}) << ((ex == 0) ? 0 : int'(ex) - 1);
    my = 300'({ey != 0, fy}) << ((ey == 0) ? 0 : int'(ey) - 1);
    if (sx == sy) begin mm = mx + my; rs = sx; end
    else if (mx >= my) begin mm = mx - my; rs = sx; end
    else begin mm = my - mx; rs = sy; end
    if (mm == 0) return {((sx == sy) ? sx : (m == 2'd3)), 31'h0, 3'b000};
    p = 0;
    for (int i = 0; i < 300; i++) if (mm[i]) p = i;
    sh = (p > 23) ? p - 23 : 0;
    ones = '1;
    q = mm >> sh;
    rem = mm & ~(ones << sh);
    inc = 1'b0;
    if (sh > 0) begin
      half = 300'(1) << (sh - 1);
      case (m)
        2'd0: inc = (rem > half) || (rem == half && q[0]);
        2'd2: inc = !rs && rem != 0;
        2'd3: inc = rs && rem != 0;
        default: inc = 1'b0;
      endcase
    end
    q = q + 300'(inc);
    if (q[24]) begin q = q >> 1; sh++; end
    fld = q[23] ? sh + 1 : 0;
    if (fld >= 255) begin
      if (m == 2'd0 || (m == 2'd2 && !rs) || (m == 2'd3 && rs))
        return {rs, 8'hFF, 23'h0, 3'b100};
      return {rs, 8'hFE, 23'h7FFFFF, 3'b100};
    end
    return {rs, fld[7:0], q[22:0], 1'b0, (fld == 0 && q[22:0] != 0), 1'b0};
  endfunction

  task automatic check_head();
    exp_t e;
    string t;
    if (eq.size() == 3) begin
      e = eq.pop_front();
      t = tq.pop_front();
      total++;
      if (out_valid !== e.v) begin
        bad++;
        $display("FAIL R1 out_valid actual=%b expected=%b", out_valid, e.v);
      end
      if (e.v) begin
        total++;
        if ({sum_out, flag_ovf, flag_unf, flag_inv} !== {e.r, e.o, e.u, e.i}) begin
          bad++;
          $display("FAIL %s actual=%h o%b u%b i%b expected=%h o%b u%b i%b", t,
                   sum_out, flag_ovf, flag_unf, flag_inv, e.r, e.o, e.u, e.i);
        end
      end
    end
  endtask

  task automatic step(input logic v, input logic [31:0] x, input logic [31:0] y,
                      input logic s, input logic [1:0] m, input string t);
    exp_t e;
    @(negedge clk);
    check_head();
    in_valid = v; op_a = x; op_b = y; op_sub = s; rnd_mode = m;
    e.v = v;
    if (v) {e.r, e.o, e.u, e.i} = ref_add(x, y, s, m);
    else   {e.r, e.o, e.u, e.i} = '0;
    eq.push_back(e);
    tq.push_back(t);
  endtask

  task automatic all_modes(input logic [31:0] x, input logic [31:0] y,
                           input logic s, input string t);
    for (int k = 0; k < 4; k++) step(1'b1, x, y, s, 2'(k), t);
  endtask

  function automatic logic [31:0] rnd_val();
    int k;
    k = $urandom_range(0, 15);
    case (k)
      0: return 32'h7F800000 | {$urandom_range(0, 1), 31'h0};
      1: return 32'h7FC00000 | 32'($urandom_range(0, 255));
      2: return {$urandom_range(0, 1) != 0, 31'h0};
      3: return {$urandom_range(0, 1) != 0, 8'h00, 23'($urandom)};
      4: return {$urandom_range(0, 1) != 0, 8'hFE, 23'($urandom)};
      default: return {$urandom_range(0, 1) != 0, 8'($urandom_range(1, 254)), 23'($urandom)};
    endcase
  endfunction

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; op_sub = 1'b0; rnd_mode = '0;
    repeat (3) @(negedge clk);
    // R13: reset state
    total++;
    if ({out_valid, sum_out, flag_ovf, flag_unf, flag_inv} !== 36'h0) begin
      bad++;
      $display("FAIL R13 reset outputs actual=%h expected=0",
               {out_valid, sum_out, flag_ovf, flag_unf, flag_inv});
    end
    rst = 1'b0;

    step(1, 32'h3F800000, 32'h3F800000, 0, 0, "R2 1+1");
    step(1, 32'h3FC00000, 32'h3E800000, 0, 0, "R2 1.5+0.25");
    step(1, 32'hC0200000, 32'h3F800000, 0, 0, "R2 -2.5+1");
    step(0, 0, 0, 0, 0, "R1 gap");
    step(1, 32'h40400000, 32'h3F800000, 1, 0, "R3 3-1");
    step(1, 32'h3F800000, 32'hBF800000, 1, 0, "R3 1-(-1)");
    step(1, 32'h3F800000, 32'h33800000, 0, 0, "R4 tie even down");
    step(1, 32'h3F800001, 32'h33800000, 0, 0, "R4 tie odd up");
    step(1, 32'h3F800000, 32'h33800001, 0, 0, "R4 above half");
    step(1, 32'h4B000000, 32'h00000001, 0, 2, "R4 sticky far");
    step(1, 32'h3F800000, 32'h00000001, 1, 0, "R4 sticky sub");
    all_modes(32'h3F800000, 32'h33C00000, 0, "R5 modes pos");
    all_modes(32'hBF800000, 32'hB3C00000, 0, "R5 modes neg");
    all_modes(32'h3F800000, 32'h00000001, 1, "R5 modes sub sticky");
    step(1, 32'h3F800000, 32'h3F7FFFFF, 1, 0, "R6 cancel");
    step(1, 32'h3F800001, 32'h3F800000, 1, 0, "R6 cancel ulp");
    step(1, 32'h00400000, 32'h00400000, 0, 0, "R7 denorm to normal");
    step(1, 32'h00000001, 32'h00000001, 0, 0, "R7 min denorms");
    step(1, 32'h00800000, 32'h00000001, 1, 0, "R7 normal to denorm");
    step(1, 32'h7FC00000, 32'h3F800000, 0, 0, "R8 nan in");
    step(1, 32'h3F800000, 32'h7F800001, 0, 0, "R8 snan in");
    step(1, 32'h7F800000, 32'h7F800000, 1, 0, "R8 inf-inf");
    step(1, 32'h7F800000, 32'hFF800000, 0, 0, "R8 inf+-inf");
    step(1, 32'h7F800000, 32'h3F800000, 0, 0, "R9 inf+1");
    step(1, 32'hFF800000, 32'h7E000000, 0, 0, "R9 -inf+big");
    step(1, 32'h3F800000, 32'hFF800000, 1, 0, "R9 1-(-inf)");
    step(1, 32'h7F800000, 32'h7F800000, 0, 0, "R9 inf+inf");
    step(1, 32'h00000000, 32'h80000000, 0, 0, "R10 +0-0 near");
    step(1, 32'h00000000, 32'h80000000, 0, 3, "R10 +0-0 down");
    step(1, 32'h80000000, 32'h80000000, 0, 0, "R10 -0-0");
    step(1, 32'h3F800000, 32'h3F800000, 1, 3, "R10 1-1 down");
    step(1, 32'h3F800000, 32'h3F800000, 1, 2, "R10 1-1 up");
    all_modes(32'h7F7FFFFF, 32'h7F7FFFFF, 0, "R11 max+max");
    all_modes(32'hFF7FFFFF, 32'hFF7FFFFF, 0, "R11 -max-max");
    all_modes(32'h7F7FFFFF, 32'h73000000, 0, "R11 max+half ulp");
    all_modes(32'hFF7FFFFF, 32'h73000000, 1, "R11 -max-half ulp");
    step(1, 32'h00400000, 32'h00000001, 0, 0, "R12 denorm sum");
    step(1, 32'h00800000, 32'h00400000, 1, 0, "R12 normal minus");
    step(1, 32'h80000003, 32'h00000001, 0, 0, "R12 neg denorm");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] x, y;
      x = rnd_val();
      y = rnd_val();
      if ($urandom_range(0, 1) == 1 && x[30:23] > 2 && x[30:23] < 253)
        y[30:23] = x[30:23] + 8'($urandom_range(0, 4)) - 8'd2;
      if ($urandom_range(0, 7) == 0) step(0, 0, 0, 0, 0, "R1 random gap");
      step(1, x, y, $urandom_range(0, 1) != 0, 2'($urandom_range(0, 3)), "R2 R5 random");
    end
    repeat (4) step(0, 0, 0, 0, 0, "R1 drain");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule